// File: doc/BRIEF.md
# Converter Serial Port Interface

This block is the digital serial port of a multichannel 12-bit converter. A host loads a short 5-bit control word over a data input framed by an active-low transmit sync. Of those bits, the first three (MSB first) select the channel, and the last two are kept as general control flags. The host reads results back as 16-bit frames framed by an active-low receive sync. Each frame carries a zero, then the channel address that came with the result, then the twelve result bits, all MSB first.

A mode pin picks the clocking. With the pin high the port is a slave: the serial clock and receive sync come from outside and are brought into the system clock domain through synchronizer stages. With the pin low the port is a master. It divides the system clock by an even ratio to make its own serial clock, and it sends a frame on its own whenever a result is waiting.

Results enter through a valid/ready stream with a single holding slot. The slot accepts a result only when it is empty (ready high). A result stays in the slot until a read frame starts, and that start frees the slot. While the slot is full, ready stays low and the source must hold its data. A slave read that starts with the slot empty sends the last result again. A coding pin picks straight binary or two's complement for the data field.

Top module: `adc_sport`

## Requirements
- R1: After reset, dout is 0, ctl_addr and ctl_flags are 0, res_ready is 1, sclk_out is 0 and rfs_n_out is 1.
- R2: The first five serial-clock falling edges after tfs_n goes low each capture din, MSB first. After the fifth edge, ctl_addr takes bits 4..2 and ctl_flags takes bits 1..0.
- R3: Falling edges after the fifth one, while tfs_n stays low, do not change ctl_addr or ctl_flags.
- R4: If tfs_n rises before the fifth edge, ctl_addr and ctl_flags keep their previous values.
- R5: A read frame presents bit 15 first and bit 0 last. The frame is one 0, then the result's 3-bit address, then 12 data bits. Each bit holds until the next serial-clock falling edge. dout is 0 whenever no frame is active.
- R6: With twos_sel low the data field equals res_data. With twos_sel high, bit 11 of the data field is inverted, which converts offset binary to two's complement.
- R7: In slave mode, rfs_n_in rising mid-frame ends the frame and drives dout to 0. The next frame starts again at the leading zero, with the same result.
- R8: res_ready is high exactly when the slot is empty. A handshake fills the slot, valid is ignored while the slot is full, and the start of a read frame empties the slot.
- R9: With mode_slave low, sclk_out toggles every DIV/2 system clocks. With mode_slave high, sclk_out is 0 and rfs_n_out is 1.
- R10: In master mode a frame starts only while a result is held. It begins on a sclk_out rising edge, holds rfs_n_out low for exactly 16 serial-clock periods, and changes dout only on rising edges.
- R11: With tfs_n and rfs_n_in driven together, one frame both loads the control word and returns a full result frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the master serial-clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_slave | input | 1 | 1 = external serial clock and receive sync, 0 = generated |
| twos_sel | input | 1 | 1 = two's complement data field, 0 = straight binary |
| sclk_in | input | 1 | External serial clock (slave mode) |
| rfs_n_in | input | 1 | External receive sync, active low (slave mode) |
| tfs_n | input | 1 | Transmit sync, active low |
| din | input | 1 | Serial control data in |
| sclk_out | output | 1 | Generated serial clock (master mode), else 0 |
| rfs_n_out | output | 1 | Generated receive sync (master mode), else 1 |
| dout | output | 1 | Serial result data out |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready (slot empty) |
| res_data | input | 12 | Conversion result, offset binary |
| res_addr | input | 3 | Channel address of the result |
| ctl_addr | output | 3 | Stored channel address |
| ctl_flags | output | 2 | Stored control flags |

## Verification
The bench builds the port with DIV = 4 and SYNC_STAGES = 2. With these values a master frame lasts 64 system clocks, so the exact length of receive sync and the half-period of the serial clock can both be counted cycle by cycle. In slave mode the bench holds each serial-clock level for six system clocks. That exceeds the three-cycle synchronizer and edge-detect latency, so each bit can be sampled just before the falling edge that retires it.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;
  localparam int DATA_W  = 12;
  localparam int ADDR_W  = 3;
  localparam int CTL_W   = 5;
  localparam int FLAG_W  = CTL_W - ADDR_W;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int TXC_W   = $clog2(FRAME_W);
  localparam int RXC_W   = $clog2(CTL_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } result_t;
endpackage

// File: rtl/adc_sport_sync.sv
module adc_sport_sync #(
  parameter int       W       = 4,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_sport_clkgen.sv
module adc_sport_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // Pulses mark the edge at which sclk is about to change.
  assign rise = en & wrap & ~sclk;
  assign fall = en & wrap & sclk;
endmodule

// File: rtl/adc_sport_rx.sv
module adc_sport_rx
  import adc_sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  input  logic             sync_n,
  input  logic             din,
  output logic [CTL_W-1:0] ctl
);
  logic [CTL_W-1:0] shreg;
  logic [RXC_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      ctl   <= '0;
    end else if (sync_n) begin
      cnt <= '0;                       // partial word dropped
    end else if (fall_evt && cnt < RXC_W'(CTL_W)) begin
      shreg <= {shreg[CTL_W-2:0], din};
      cnt   <= cnt + 1'b1;
      if (cnt == RXC_W'(CTL_W - 1))
        ctl <= {shreg[CTL_W-2:0], din};
    end
  end
endmodule

// File: rtl/adc_sport_tx.sv
module adc_sport_tx
  import adc_sport_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               adv,
  input  logic [FRAME_W-1:0] frame,
  output logic               dout,
  output logic               busy
);
  logic [FRAME_W-1:0] shreg;
  logic [TXC_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      shreg <= frame;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (abort) begin
      shreg <= '0;
      busy  <= 1'b0;
    end else if (busy && adv) begin
      if (cnt == TXC_W'(FRAME_W - 1)) begin
        shreg <= '0;
        busy  <= 1'b0;
      end else begin
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign dout = shreg[FRAME_W-1];
endmodule

// File: rtl/adc_sport.sv
module adc_sport
  import adc_sport_pkg::*;
#(
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_slave,
  input  logic              twos_sel,
  input  logic              sclk_in,
  input  logic              rfs_n_in,
  input  logic              tfs_n,
  input  logic              din,
  output logic              sclk_out,
  output logic              rfs_n_out,
  output logic              dout,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [FLAG_W-1:0] ctl_flags
);
  // Slave-side pins into the system clock domain
  logic s_sclk, s_rfs_n, s_tfs_n, s_din;
  logic p_sclk, p_rfs_n;

  adc_sport_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, rfs_n_in, tfs_n, din}),
    .q     ({s_sclk, s_rfs_n, s_tfs_n, s_din})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sclk  <= 1'b1;
      p_rfs_n <= 1'b1;
    end else begin
      p_sclk  <= s_sclk;
      p_rfs_n <= s_rfs_n;
    end
  end

  logic s_fall, s_rfs_fall, s_rfs_rise;
  assign s_fall     = p_sclk & ~s_sclk;
  assign s_rfs_fall = p_rfs_n & ~s_rfs_n;
  assign s_rfs_rise = ~p_rfs_n & s_rfs_n;

  // Master serial clock
  logic m_sclk, m_rise, m_fall;
  adc_sport_clkgen #(.DIV(DIV)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (~mode_slave),
    .sclk  (m_sclk),
    .rise  (m_rise),
    .fall  (m_fall)
  );

  // Result holding slot
  result_t hold;
  logic    pending;
  logic    busy, start, abort, adv, fall_evt;
  logic [DATA_W-1:0]  coded;
  logic [FRAME_W-1:0] frame;

  assign res_ready = ~pending;
  assign start     = mode_slave ? s_rfs_fall : (m_rise & pending & ~busy);
  assign abort     = mode_slave & s_rfs_rise;
  assign adv       = mode_slave ? s_fall : m_rise;
  assign fall_evt  = mode_slave ? s_fall : m_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      pending <= 1'b0;
    end else begin
      if (start) pending <= 1'b0;
      if (res_valid && res_ready) begin
        hold    <= '{addr: res_addr, data: res_data};
        pending <= 1'b1;
      end
    end
  end

  assign coded = twos_sel ? {~hold.data[DATA_W-1], hold.data[DATA_W-2:0]} : hold.data;
  assign frame = {1'b0, hold.addr, coded};

  adc_sport_tx u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .abort (abort),
    .adv   (adv),
    .frame (frame),
    .dout  (dout),
    .busy  (busy)
  );

  logic [CTL_W-1:0] ctl;
  adc_sport_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .sync_n   (s_tfs_n),
    .din      (s_din),
    .ctl      (ctl)
  );

  assign ctl_addr  = ctl[CTL_W-1 -: ADDR_W];
  assign ctl_flags = ctl[FLAG_W-1:0];

  assign sclk_out  = mode_slave ? 1'b0 : m_sclk;
  assign rfs_n_out = mode_slave ? 1'b1 : ~busy;
endmodule

// File: rtl/adc_sport_chk.sv
module adc_sport_chk
  import adc_sport_pkg::*;
#(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic mode_slave,
  input logic sclk_out,
  input logic rfs_n_out,
  input logic dout,
  input logic res_valid,
  input logic res_ready
);
  logic        last_sclk;
  logic [31:0] half_cnt, mst_cnt, low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sclk <= 1'b0;
      half_cnt  <= '0;
      mst_cnt   <= '0;
      low_cnt   <= '0;
    end else begin
      last_sclk <= sclk_out;
      half_cnt  <= (sclk_out != last_sclk) ? 32'd1 : half_cnt + 1;
      mst_cnt   <= mode_slave ? '0 : ((mst_cnt == '1) ? mst_cnt : mst_cnt + 1);
      low_cnt   <= (mode_slave || rfs_n_out) ? '0 : low_cnt + 1;
    end
  end

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_ready);

  assert_idle_dout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && rfs_n_out) |-> !dout);

  assert_sclk_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && mst_cnt > 32'(DIV) && sclk_out != last_sclk) |-> half_cnt == 32'(DIV / 2));

  assert_frame_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_slave && rfs_n_out && low_cnt != 0) |-> low_cnt == 32'(FRAME_W * DIV));
endmodule

bind adc_sport adc_sport_chk #(.DIV(DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_slave (mode_slave),
  .sclk_out   (sclk_out),
  .rfs_n_out  (rfs_n_out),
  .dout       (dout),
  .res_valid  (res_valid),
  .res_ready  (res_ready)
);

// File: tb/adc_sport_test.sv
module adc_sport_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n, mode_slave, twos_sel, sclk_in, rfs_n_in, tfs_n, din;
  logic sclk_out, rfs_n_out, dout, res_valid, res_ready;
  logic [11:0] res_data;
  logic [2:0]  res_addr, ctl_addr;
  logic [1:0]  ctl_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  adc_sport #(.DIV(DIV), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave), .twos_sel(twos_sel),
    .sclk_in(sclk_in), .rfs_n_in(rfs_n_in), .tfs_n(tfs_n), .din(din),
    .sclk_out(sclk_out), .rfs_n_out(rfs_n_out), .dout(dout),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_addr(res_addr), .ctl_addr(ctl_addr), .ctl_flags(ctl_flags)
  );

  // {twos_sel, addr, data, expected frame}
  localparam logic [31:0] VEC [0:5] = '{
    {1'b0, 3'h5, 12'hA5C, 16'h5A5C},
    {1'b0, 3'h0, 12'hFFF, 16'h0FFF},
    {1'b1, 3'h7, 12'h800, 16'h7000},
    {1'b1, 3'h2, 12'h123, 16'h2923},
    {1'b0, 3'h6, 12'h000, 16'h6000},
    {1'b1, 3'h1, 12'h7FF, 16'h1FFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic tw, input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    twos_sel = tw;
    res_addr = a;
    res_data = d;
    while (!res_ready) @(negedge clk);
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic xfer(input logic do_w, input logic do_r, input logic [4:0] wbits,
                      input int nedge, output logic [15:0] got);
    got = '0;
    @(negedge clk);
    if (do_w) tfs_n = 1'b0;
    if (do_r) rfs_n_in = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nedge; i++) begin
      din = (i < 5) ? wbits[4-i] : 1'b1;
      wait_clk(3);
      if (i < 16) got = {got[14:0], dout};
      sclk_in = 1'b0;
      wait_clk(6);
      sclk_in = 1'b1;
      wait_clk(6);
    end
  endtask

  task automatic end_frame();
    tfs_n = 1'b1;
    rfs_n_in = 1'b1;
    wait_clk(6);
  endtask

  task automatic master_capture(output logic [15:0] got, output int nfall, output int lowcnt);
    logic prev_s;
    bit   seen;
    got = '0; nfall = 0; lowcnt = 0; seen = 0;
    prev_s = sclk_out;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (!rfs_n_out) begin
        seen = 1;
        lowcnt++;
        if (prev_s && !sclk_out) begin
          got = {got[14:0], dout};
          nfall++;
        end
      end else if (seen) begin
        break;
      end
      prev_s = sclk_out;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    int nfall, lowcnt, per;
    rst_n = 1'b0; mode_slave = 1'b1; twos_sel = 1'b0;
    sclk_in = 1'b1; rfs_n_in = 1'b1; tfs_n = 1'b1; din = 1'b0;
    res_valid = 1'b0; res_data = '0; res_addr = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    chk(dout == 1'b0,      "R1 dout", 32'(dout), 0);
    chk(ctl_addr == 3'd0,  "R1 ctl_addr", 32'(ctl_addr), 0);
    chk(ctl_flags == 2'd0, "R1 ctl_flags", 32'(ctl_flags), 0);
    chk(res_ready == 1'b1, "R1 res_ready", 32'(res_ready), 1);
    chk(sclk_out == 1'b0 && rfs_n_out == 1'b1, "R1 master pins", {sclk_out, rfs_n_out}, 32'b01);

    // R5 / R6 / R8 table of slave read frames
    foreach (VEC[k]) begin
      push(VEC[k][31], VEC[k][30:28], VEC[k][27:16]);
      chk(res_ready == 1'b0, "R8 slot full", 32'(res_ready), 0);
      xfer(1'b0, 1'b1, 5'd0, 16, got);
      chk(got == VEC[k][15:0], VEC[k][31] ? "R6 twos frame" : "R5 frame", 32'(got), 32'(VEC[k][15:0]));
      chk(dout == 1'b0, "R5 idle after 16 edges", 32'(dout), 0);
      end_frame();
      chk(res_ready == 1'b1, "R8 slot freed", 32'(res_ready), 1);
    end

    // R2 full control write
    xfer(1'b1, 1'b0, 5'b10110, 5, got);
    end_frame();
    chk({ctl_addr, ctl_flags} == 5'b10110, "R2 control word", 32'({ctl_addr, ctl_flags}), 32'b10110);

    // R3 extra edges ignored
    xfer(1'b1, 1'b0, 5'b01101, 9, got);
    end_frame();
    chk({ctl_addr, ctl_flags} == 5'b01101, "R3 extra edges", 32'({ctl_addr, ctl_flags}), 32'b01101);

    // R4 partial write dropped
    xfer(1'b1, 1'b0, 5'b11000, 3, got);
    end_frame();
    chk({ctl_addr, ctl_flags} == 5'b01101, "R4 partial write", 32'({ctl_addr, ctl_flags}), 32'b01101);

    // R7 abort mid-frame, then restart
    push(1'b0, 3'h4, 12'h3C3);
    xfer(1'b0, 1'b1, 5'd0, 5, got);
    chk(got[4:0] == 5'b01000, "R7 first bits", 32'(got[4:0]), 32'b01000);
    end_frame();
    chk(dout == 1'b0, "R7 dout after abort", 32'(dout), 0);
    xfer(1'b0, 1'b1, 5'd0, 16, got);
    end_frame();
    chk(got == 16'h43C3, "R7 restarted frame", 32'(got), 32'h43C3);

    // R11 tied syncs
    push(1'b0, 3'h2, 12'h055);
    xfer(1'b1, 1'b1, 5'b11111, 16, got);
    end_frame();
    chk(got == 16'h2055, "R11 read part", 32'(got), 32'h2055);
    chk({ctl_addr, ctl_flags} == 5'b11111, "R11 write part", 32'({ctl_addr, ctl_flags}), 32'b11111);

    // R8 back-pressure: valid ignored while full
    push(1'b0, 3'h1, 12'hABC);
    @(negedge clk);
    res_addr = 3'h7; res_data = 12'h111; res_valid = 1'b1;
    wait_clk(5);
    chk(res_ready == 1'b0, "R8 held off", 32'(res_ready), 0);
    res_valid = 1'b0;
    xfer(1'b0, 1'b1, 5'd0, 16, got);
    end_frame();
    chk(got == 16'h1ABC, "R8 first result kept", 32'(got), 32'h1ABC);

    // R9 / R10 master mode
    @(negedge clk);
    mode_slave = 1'b0;
    wait_clk(8);
    while (sclk_out) @(negedge clk);
    while (!sclk_out) @(negedge clk);
    per = 0;
    while (sclk_out) begin @(negedge clk); per++; end
    while (!sclk_out) begin @(negedge clk); per++; end
    chk(per == DIV, "R9 sclk period", 32'(per), 32'(DIV));
    lowcnt = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!rfs_n_out) lowcnt++;
    end
    chk(lowcnt == 0, "R10 no frame without result", 32'(lowcnt), 0);
    push(1'b0, 3'h5, 12'h321);
    master_capture(got, nfall, lowcnt);
    chk(got == 16'h5321, "R10 master frame data", 32'(got), 32'h5321);
    chk(nfall == 16, "R10 falling edges in frame", 32'(nfall), 16);
    chk(lowcnt == 16 * DIV, "R10 sync low length", 32'(lowcnt), 32'(16 * DIV));
    chk(dout == 1'b0, "R5 master idle dout", 32'(dout), 0);
    chk(res_ready == 1'b1, "R8 master consumed", 32'(res_ready), 1);

    // R9 back to slave
    @(negedge clk);
    mode_slave = 1'b1;
    wait_clk(3);
    chk(sclk_out == 1'b0 && rfs_n_out == 1'b1, "R9 slave quiet", {sclk_out, rfs_n_out}, 32'b01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule